// File: doc/BRIEF.md
# Command-Parameter Bank Mapper

This block maps an 8-bit CPU's upper address space and a video controller's pattern space onto larger external memories. Software programs it in two steps. A write into the command window stores a 4-bit command index. A later write into the parameter window applies its data byte to whichever command is stored. The stored index persists, so several parameter writes can target the same command.

On the CPU side, the four 8 KiB windows from $6000 to $DFFF can each be pointed at a program ROM bank. The top window, $E000-$FFFF, is pinned to the final ROM bank. The lowest window, $6000-$7FFF, can also be switched to work RAM, which has its own enable bit. When RAM is chosen but not enabled, neither memory is selected and the block flags open bus. On the video side, the block forms a character-memory address from eight 1 KiB bank numbers, and it derives the nametable page-select bit from a 2-bit mirroring mode. Commands D, E and F carry no state here. They are passed on as a strobe that carries the data byte. Every output is a register, so each one reflects the inputs and the mapping state as they were at the preceding clock edge.

Top module: `cmd_bank_mapper`

## Requirements
- R1: A write to $8000-$9FFF stores data bits 3:0 as the command index. Data bits 7:4 are ignored. The index only changes on such a write.
- R2: A write to $A000-$BFFF applies the data byte to the stored command. Repeated parameter writes keep using the same stored index.
- R3: Commands 0 through 7 set the 8-bit bank for video slot n, which covers addresses n*$400 to n*$400+$3FF. For a video address below $2000, chr_addr = {bank, ppu_addr[9:0]} and chr_ce = 1.
- R4: Commands 9, A and B set the banks for CPU $8000, $A000 and $C000. Only data bits 5:0 are kept. For a read, prg_addr = {bank, cpu_addr[12:0]} and prg_rom_ce = 1.
- R5: A read of $E000-$FFFF always gives prg_addr = {LAST_BANK, cpu_addr[12:0]}, where LAST_BANK is the bank count minus one (63 by default).
- R6: In the command 8 byte, bit 7 is the RAM enable, bit 6 selects RAM (1) or ROM (0), and bits 5:0 give the bank. With bit 6 = 0, a read of $6000-$7FFF selects ROM at that bank.
- R7: With bits 7 and 6 both set, any access to $6000-$7FFF asserts prg_ram_ce. A write there also asserts prg_ram_we. prg_addr carries the bank from bits 5:0.
- R8: With bit 6 = 1 and bit 7 = 0, an access to $6000-$7FFF raises open_bus, asserts no chip enable, and asserts no RAM write.
- R9: Command C sets the mirroring mode from data bits 1:0. For a video address at $2000 or above, nt_ce = 1 and nt_a10 is: mode 0 gives ppu_addr[10], mode 1 gives ppu_addr[11], mode 2 gives 0, mode 3 gives 1.
- R10: A parameter write under command D, E or F produces a one-cycle irq_cmd_we, with irq_cmd_sel 0, 1 or 2 respectively and irq_cmd_data equal to the byte. No bank or mirroring state changes.
- R11: prg_rom_ce stays 0 for any CPU write cycle, so ROM never drives the bus while register writes are latched.
- R12: Reset clears the command index, all banks and the mirroring mode, and disables RAM. After reset, $6000 reads ROM bank 0 and the mirroring mode is vertical.
- R13: All outputs are registered. A translation in the same cycle as a parameter write that changes the mapping uses the old mapping. The new mapping appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write, one per high cycle |
| ppu_addr | input | 14 | Video bus address |
| prg_addr | output | 19 | Translated program ROM/RAM address |
| prg_rom_ce | output | 1 | Program ROM enable (reads only) |
| prg_ram_ce | output | 1 | Work RAM enable |
| prg_ram_we | output | 1 | Work RAM write enable |
| open_bus | output | 1 | RAM window selected but disabled |
| chr_addr | output | 18 | Translated character-memory address |
| chr_ce | output | 1 | Character memory enable |
| nt_a10 | output | 1 | Nametable page select |
| nt_ce | output | 1 | Nametable access |
| irq_cmd_we | output | 1 | Strobe for commands D-F |
| irq_cmd_sel | output | 2 | 0/1/2 for commands D/E/F |
| irq_cmd_data | output | 8 | Parameter byte for commands D-F |

## Verification
Two things can fall in the same clock edge: a parameter write that rewrites a character bank, and a video-side lookup inside that same slot. The bench holds the video address in slot 0 while it writes a new bank for that slot. It then checks that the output captured at the write edge still carries the old bank number, and that the next cycle carries the new one. A second collision is a write into the program windows while ROM would otherwise be enabled. That case is judged by requiring prg_rom_ce to be low in the cycle that follows the write.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam int CHR_SLOTS = 8;
  localparam int PRG_SLOTS = 3;

  localparam logic [2:0] WIN_LOW  = 3'b011;
  localparam logic [2:0] WIN_CMD  = 3'b100;
  localparam logic [2:0] WIN_PAR  = 3'b101;
  localparam logic [2:0] WIN_B2   = 3'b110;
  localparam logic [2:0] WIN_TOP  = 3'b111;

  localparam logic [3:0] OP_LOWWIN = 4'h8;
  localparam logic [3:0] OP_PRG0   = 4'h9;
  localparam logic [3:0] OP_MIRROR = 4'hC;
  localparam logic [3:0] OP_IRQ0   = 4'hD;
endpackage

// File: rtl/cbm_cmd_regs.sv
module cbm_cmd_regs
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W = 6,
  parameter int CHR_BANK_W = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [15:0]                              cpu_addr,
  input  logic [7:0]                               cpu_data,
  input  logic                                     cpu_wr,
  output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]     chr_bank,
  output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]     prg_bank,
  output logic [PRG_BANK_W-1:0]                    low_bank,
  output logic                                     low_ram_sel,
  output logic                                     low_ram_en,
  output mirror_e                                  mirror,
  output logic                                     irq_we,
  output logic [1:0]                               irq_sel,
  output logic [7:0]                               irq_data
);
  logic [3:0] cmd_q;
  logic       cmd_wr, par_wr;

  assign cmd_wr = cpu_wr && (cpu_addr[15:13] == WIN_CMD);
  assign par_wr = cpu_wr && (cpu_addr[15:13] == WIN_PAR);

  always_ff @(posedge clk) begin
    if (rst)         cmd_q <= '0;
    else if (cmd_wr) cmd_q <= cpu_data[3:0];
  end

  for (genvar gi = 0; gi < CHR_SLOTS; gi++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst)
        chr_bank[gi] <= '0;
      else if (par_wr && cmd_q == 4'(gi))
        chr_bank[gi] <= cpu_data[CHR_BANK_W-1:0];
    end
  end

  for (genvar gj = 0; gj < PRG_SLOTS; gj++) begin : g_prg
    always_ff @(posedge clk) begin
      if (rst)
        prg_bank[gj] <= '0;
      else if (par_wr && cmd_q == 4'(OP_PRG0 + gj))
        prg_bank[gj] <= cpu_data[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_bank    <= '0;
      low_ram_sel <= 1'b0;
      low_ram_en  <= 1'b0;
      mirror      <= MIR_VERT;
    end else if (par_wr) begin
      if (cmd_q == OP_LOWWIN) begin
        low_bank    <= cpu_data[PRG_BANK_W-1:0];
        low_ram_sel <= cpu_data[6];
        low_ram_en  <= cpu_data[7];
      end
      if (cmd_q == OP_MIRROR)
        mirror <= mirror_e'(cpu_data[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_we   <= 1'b0;
      irq_sel  <= '0;
      irq_data <= '0;
    end else begin
      irq_we   <= par_wr && (cmd_q >= OP_IRQ0);
      irq_sel  <= cmd_q[1:0] - 2'd1;
      irq_data <= cpu_data;
    end
  end

  // R1: command index changes only after a command-window write
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(cpu_wr) && $past(cpu_addr[15:13]) == WIN_CMD)) |-> $stable(cmd_q));
  // R10: the strobe always follows a CPU write
  p_irq_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    irq_we |-> $past(cpu_wr));
  // R10: bank state untouched by the forwarded commands
  p_irq_no_bank_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_we) |-> ($stable(prg_bank) && $stable(chr_bank) && $stable(low_bank)));
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W = 6,
  parameter int PRG_BANKS  = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [15:0]                          cpu_addr,
  input  logic                                 cpu_wr,
  input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank,
  input  logic [PRG_BANK_W-1:0]                low_bank,
  input  logic                                 low_ram_sel,
  input  logic                                 low_ram_en,
  output logic [PRG_BANK_W+12:0]               prg_addr,
  output logic                                 rom_ce,
  output logic                                 ram_ce,
  output logic                                 ram_we,
  output logic                                 open_bus
);
  localparam int                  PRG_AW    = PRG_BANK_W + 13;
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = PRG_BANK_W'(PRG_BANKS - 1);

  logic [PRG_BANK_W-1:0] bank_d;
  logic                  rom_hit, ram_hit, open_hit;

  always_comb begin
    bank_d   = '0;
    rom_hit  = 1'b0;
    ram_hit  = 1'b0;
    open_hit = 1'b0;
    unique case (cpu_addr[15:13])
      WIN_LOW: begin
        bank_d = low_bank;
        if (!low_ram_sel)     rom_hit  = 1'b1;
        else if (low_ram_en)  ram_hit  = 1'b1;
        else                  open_hit = 1'b1;
      end
      WIN_CMD: begin bank_d = prg_bank[0]; rom_hit = 1'b1; end
      WIN_PAR: begin bank_d = prg_bank[1]; rom_hit = 1'b1; end
      WIN_B2:  begin bank_d = prg_bank[2]; rom_hit = 1'b1; end
      WIN_TOP: begin bank_d = LAST_BANK;   rom_hit = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_addr <= '0;
      rom_ce   <= 1'b0;
      ram_ce   <= 1'b0;
      ram_we   <= 1'b0;
      open_bus <= 1'b0;
    end else begin
      prg_addr <= PRG_AW'({bank_d, cpu_addr[12:0]});
      rom_ce   <= rom_hit && !cpu_wr;
      ram_ce   <= ram_hit;
      ram_we   <= ram_hit && cpu_wr;
      open_bus <= open_hit;
    end
  end

  // R11: ROM is never enabled for a write cycle
  p_no_rom_on_write_r11: assert property (@(posedge clk) disable iff (rst)
    $past(cpu_wr) |-> !rom_ce);
  // R5: top window always lands in the final bank
  p_fixed_top_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_addr[15:13]) == WIN_TOP) |-> prg_addr[PRG_AW-1:13] == LAST_BANK);
  // R8: at most one source answers
  p_one_source_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({rom_ce, ram_ce, open_bus}) <= 1);
  // R8: disabled RAM is never written
  p_open_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    open_bus |-> !ram_we && !ram_ce);
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
  import cbm_pkg::*;
#(
  parameter int CHR_BANK_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [13:0]                          ppu_addr,
  input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank,
  input  mirror_e                              mirror,
  output logic [CHR_BANK_W+9:0]                chr_addr,
  output logic                                 chr_ce,
  output logic                                 nt_a10,
  output logic                                 nt_ce
);
  localparam int CHR_AW = CHR_BANK_W + 10;

  logic a10_d;

  always_comb begin
    unique case (mirror)
      MIR_VERT:   a10_d = ppu_addr[10];
      MIR_HORZ:   a10_d = ppu_addr[11];
      MIR_ONE_LO: a10_d = 1'b0;
      default:    a10_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_addr <= '0;
      chr_ce   <= 1'b0;
      nt_a10   <= 1'b0;
      nt_ce    <= 1'b0;
    end else begin
      chr_addr <= CHR_AW'({chr_bank[ppu_addr[12:10]], ppu_addr[9:0]});
      chr_ce   <= !ppu_addr[13];
      nt_a10   <= a10_d;
      nt_ce    <= ppu_addr[13];
    end
  end

  // R3: pattern and nametable accesses are exclusive
  p_chr_nt_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(chr_ce && nt_ce));
  // R9: single-screen low mode pins the page select low
  p_single_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mirror) == MIR_ONE_LO) |-> !nt_a10);
  // R9: single-screen high mode pins the page select high
  p_single_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mirror) == MIR_ONE_HI) |-> nt_a10);
endmodule

// File: rtl/cmd_bank_mapper.sv
module cmd_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W = 6,
  parameter int PRG_BANKS  = 64,
  parameter int CHR_BANK_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [15:0]               cpu_addr,
  input  logic [7:0]                cpu_data,
  input  logic                      cpu_wr,
  input  logic [13:0]               ppu_addr,
  output logic [PRG_BANK_W+12:0]    prg_addr,
  output logic                      prg_rom_ce,
  output logic                      prg_ram_ce,
  output logic                      prg_ram_we,
  output logic                      open_bus,
  output logic [CHR_BANK_W+9:0]     chr_addr,
  output logic                      chr_ce,
  output logic                      nt_a10,
  output logic                      nt_ce,
  output logic                      irq_cmd_we,
  output logic [1:0]                irq_cmd_sel,
  output logic [7:0]                irq_cmd_data
);
  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank;
  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [PRG_BANK_W-1:0]                low_bank;
  logic                                 low_ram_sel, low_ram_en;
  mirror_e                              mirror;

  cbm_cmd_regs #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)) u_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .chr_bank(chr_bank), .prg_bank(prg_bank), .low_bank(low_bank),
    .low_ram_sel(low_ram_sel), .low_ram_en(low_ram_en), .mirror(mirror),
    .irq_we(irq_cmd_we), .irq_sel(irq_cmd_sel), .irq_data(irq_cmd_data)
  );

  cbm_prg_map #(.PRG_BANK_W(PRG_BANK_W), .PRG_BANKS(PRG_BANKS)) u_prg (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .prg_bank(prg_bank), .low_bank(low_bank),
    .low_ram_sel(low_ram_sel), .low_ram_en(low_ram_en),
    .prg_addr(prg_addr), .rom_ce(prg_rom_ce), .ram_ce(prg_ram_ce),
    .ram_we(prg_ram_we), .open_bus(open_bus)
  );

  cbm_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .clk(clk), .rst(rst), .ppu_addr(ppu_addr), .chr_bank(chr_bank), .mirror(mirror),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_a10(nt_a10), .nt_ce(nt_ce)
  );

  // R12: outputs idle in the first cycle after reset
  p_reset_idle_r12: assert property (@(posedge clk)
    $past(rst) |-> !prg_ram_ce && !prg_ram_we && !irq_cmd_we && !open_bus);
endmodule

// File: tb/test_cmd_bank_mapper.sv
module test_cmd_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [18:0] prg_addr;
  logic        prg_rom_ce, prg_ram_ce, prg_ram_we, open_bus;
  logic [17:0] chr_addr;
  logic        chr_ce, nt_a10, nt_ce;
  logic        irq_cmd_we;
  logic [1:0]  irq_cmd_sel;
  logic [7:0]  irq_cmd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // snapshot of outputs right after a write edge
  logic        s_rom, s_ramwe, s_open, s_irq_we;
  logic [1:0]  s_irq_sel;
  logic [7:0]  s_irq_data;
  logic [17:0] s_chr;

  always #10 clk = ~clk;

  cmd_bank_mapper i_cmd_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .prg_addr(prg_addr), .prg_rom_ce(prg_rom_ce),
    .prg_ram_ce(prg_ram_ce), .prg_ram_we(prg_ram_we), .open_bus(open_bus),
    .chr_addr(chr_addr), .chr_ce(chr_ce), .nt_a10(nt_a10), .nt_ce(nt_ce),
    .irq_cmd_we(irq_cmd_we), .irq_cmd_sel(irq_cmd_sel), .irq_cmd_data(irq_cmd_data)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [7:0]  par;
    logic [15:0] addr;
    logic [18:0] eaddr;
    logic [2:0]  eflg;   // {rom_ce, ram_ce, open_bus}
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'h9, 8'h05, 16'h8123, {6'd5,  13'h0123}, 3'b100},  // R4
    '{4'hA, 8'hC7, 16'hA456, {6'd7,  13'h0456}, 3'b100},  // R4 upper bits dropped
    '{4'hB, 8'h3F, 16'hDFFF, {6'd63, 13'h1FFF}, 3'b100},  // R4
    '{4'h8, 8'h02, 16'h6010, {6'd2,  13'h0010}, 3'b100},  // R6
    '{4'h8, 8'h80, 16'h7000, {6'd0,  13'h1000}, 3'b100},  // R6 enable alone keeps ROM
    '{4'h8, 8'hC1, 16'h7FFE, {6'd1,  13'h1FFE}, 3'b010},  // R7
    '{4'h8, 8'h43, 16'h6000, {6'd3,  13'h0000}, 3'b001},  // R8
    '{4'h9, 8'h11, 16'hE000, {6'd63, 13'h0000}, 3'b100},  // R5
    '{4'hB, 8'h01, 16'hFFFF, {6'd63, 13'h1FFF}, 3'b100}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    s_rom = prg_rom_ce; s_ramwe = prg_ram_we; s_open = open_bus;
    s_irq_we = irq_cmd_we; s_irq_sel = irq_cmd_sel; s_irq_data = irq_cmd_data;
    s_chr = chr_addr;
    cpu_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [3:0] c, input logic [7:0] p);
    cpu_write(16'h8000, {4'h0, c});
    cpu_write(16'hA000, p);
  endtask

  task automatic cpu_probe(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic ppu_probe(input logic [13:0] a);
    @(negedge clk);
    ppu_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    chk("R12 irq idle", irq_cmd_we, 0);
    cpu_probe(16'h6000);
    chk("R12 low window rom", {prg_rom_ce, prg_ram_ce, open_bus}, 3'b100);
    chk("R12 low bank 0", prg_addr, 0);
    cpu_probe(16'h9FFF);
    chk("R12 prg bank 0", prg_addr, 19'h01FFF);
    ppu_probe(14'h1F55);
    chk("R12 chr bank 0", chr_addr, 18'h00355);
    ppu_probe(14'h2400);
    chk("R12 vertical", nt_a10, 1);

    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      set_reg(VECS[i].cmd, VECS[i].par);
      cpu_probe(VECS[i].addr);
      chk($sformatf("R4-R8 vec%0d addr", i), prg_addr, VECS[i].eaddr);
      chk($sformatf("R4-R8 vec%0d flags", i), {prg_rom_ce, prg_ram_ce, open_bus}, VECS[i].eflg);
    end

    // R3: all eight character slots
    for (int i = 0; i < 8; i++) set_reg(4'(i), 8'hA0 ^ 8'(i * 17));
    for (int i = 0; i < 8; i++) begin
      ppu_probe(14'(i * 14'h400 + 14'h3FF));
      chk($sformatf("R3 slot%0d", i), {chr_ce, chr_addr}, {1'b1, 8'hA0 ^ 8'(i * 17), 10'h3FF});
    end

    // R1: upper data bits of the command byte ignored
    cpu_write(16'h9ABC, 8'hF3);
    cpu_write(16'hB000, 8'h2A);
    ppu_probe(14'h0C05);
    chr_addr_check_r1: chk("R1 cmd low nibble", chr_addr, {8'h2A, 10'h005});
    // R2: stored command reused
    cpu_write(16'hA123, 8'h55);
    ppu_probe(14'h0C06);
    chk("R2 repeat param", chr_addr, {8'h55, 10'h006});

    // R9: mirroring modes
    for (int m = 0; m < 4; m++) begin
      set_reg(4'hC, 8'hFC | 8'(m));
      ppu_probe(14'h2400);
      chk($sformatf("R9 mode%0d 2400", m), {nt_ce, nt_a10}, {1'b1, (m == 0 || m == 3) ? 1'b1 : 1'b0});
      ppu_probe(14'h2800);
      chk($sformatf("R9 mode%0d 2800", m), {nt_ce, nt_a10}, {1'b1, (m == 1 || m == 3) ? 1'b1 : 1'b0});
    end

    // R7: RAM write
    set_reg(4'h8, 8'hC4);
    cpu_write(16'h6005, 8'h99);
    chk("R7 ram we", {s_ramwe, s_open}, 2'b10);
    // R8: disabled RAM write is blocked
    set_reg(4'h8, 8'h44);
    cpu_write(16'h6005, 8'h99);
    chk("R8 no ram we", {s_ramwe, s_open}, 2'b01);

    // R11: writes into ROM windows do not enable ROM
    cpu_write(16'hC000, 8'hFF);
    chk("R11 C000 write", s_rom, 0);
    cpu_write(16'hE123, 8'h00);
    chk("R11 E000 write", s_rom, 0);

    // R10: forwarded commands
    set_reg(4'h9, 8'h0B);
    set_reg(4'hD, 8'h81);
    chk("R10 D strobe", {s_irq_we, s_irq_sel, s_irq_data}, {1'b1, 2'd0, 8'h81});
    @(negedge clk);
    chk("R10 one cycle", irq_cmd_we, 0);
    set_reg(4'hF, 8'h12);
    chk("R10 F strobe", {s_irq_we, s_irq_sel, s_irq_data}, {1'b1, 2'd2, 8'h12});
    set_reg(4'hE, 8'h3C);
    chk("R10 E strobe", {s_irq_we, s_irq_sel, s_irq_data}, {1'b1, 2'd1, 8'h3C});
    cpu_probe(16'h8000);
    chk("R10 bank kept", prg_addr, {6'd11, 13'h0});

    // R13: same-cycle write and lookup
    ppu_probe(14'h0000);
    cpu_write(16'h8000, 8'h00);
    cpu_write(16'hA000, 8'h77);
    chk("R13 old mapping at write edge", s_chr, {8'hA0, 10'h000});
    @(negedge clk);
    chk("R13 new mapping next cycle", chr_addr, {8'h77, 10'h000});

    // R12: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    cpu_probe(16'h6000);
    chk("R12 rerun low window", {prg_rom_ce, prg_ram_ce, open_bus, prg_addr}, {3'b100, 19'h0});
    ppu_probe(14'h0010);
    chk("R12 rerun chr", chr_addr, 18'h00010);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule